// File: doc/BRIEF.md
# Display Link Lane Budget Checker

This block decides whether a display pipe may drive a serial link with the number of lanes its mode needs. It takes the pixel clock, the bandwidth each lane carries and a starting pixel depth. From these it works out the lane count and tests it against the rules of the selected platform mode. In three-pipe mode, pipes B and C draw on one shared group of lanes, so the decision also depends on what the other pipe is using at that moment.

When the lane count is not allowed and the depth is still above 18 bits per pixel, the block lowers the depth by 6 and tests again. It runs one test per clock until the request passes or the depth cannot drop further. It then reports the lane count, the final depth and whether the request passed. Two flags say whether the depth was lowered and whether the caller must redo its configuration at the new depth.

A request enters through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and every request input is captured on that edge. Upstream may hold `req_valid` high for as long as it likes, and the request stays pending. The result is a single-cycle `res_valid` pulse with no back-pressure: the result fields hold their values until the next result.

Top module: `lane_budget_check`

## Requirements
- R1: A request whose computed lane count is above 4 is never legal, in any platform mode.
- R2: When `req_mode` is 2 or 3 (restricted mode), a lane count of 2 or fewer is legal and more than 2 is illegal, whatever the pipe index and the peer state.
- R3: When `req_mode` is 0 (two-pipe mode), any lane count of 4 or fewer is legal for every pipe index.
- R4: When `req_mode` is 1 (three-pipe mode), pipe index 0 (pipe A) may use up to 4 lanes. Pipe index 1 (pipe B) may use more than 2 lanes only when the need of pipe C is zero.
- R5: In three-pipe mode, pipe index 2 (pipe C) is illegal above 2 lanes. It is also illegal when the need of pipe B is above 2. Pipe index 3 is always illegal in this mode.
- R6: The need of a peer pipe equals its lane count when both its enable bit and its on-link bit are set, and is zero otherwise. In the peer vectors, bit 0 and lane field [LANE_W-1:0] are pipe B, and bit 1 and field [2*LANE_W-1:LANE_W] are pipe C.
- R7: The lane count is ceil(pclk × bpp / (lane_bw × 8)), saturated at 2^LANE_W−1. A lane bandwidth of zero gives the saturated value.
- R8: When a test fails and the depth is above 18, the depth drops by 6 and the bandwidth-limited flag is set. The next test runs in the following cycle.
- R9: A final result that passes after at least one drop sets `res_retry`. A final result that fails (the depth is 18 or less) has `res_ok` = 0 and `res_retry` = 0.
- R10: A request taken on clock edge E0 that needs n tests raises `res_valid` for exactly one cycle, after edge E0+n. `req_ready` is low from E0 until that same edge.
- R11: After reset, `req_ready` is 1 and `res_valid`, `res_ok`, `res_retry` and `res_bw_limited` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_pipe | input | 2 | Pipe index (0 = A, 1 = B, 2 = C) |
| req_pclk | input | PCLK_W | Pixel clock |
| req_lane_bw | input | BW_W | Bandwidth per lane, in the same time base as the pixel clock |
| req_bpp | input | BPP_W | Starting bits per pixel |
| req_mode | input | 2 | Platform mode: 0 two-pipe, 1 three-pipe, 2 or 3 restricted |
| peer_en | input | 2 | Enable bits of pipes B (bit 0) and C (bit 1) |
| peer_on_link | input | 2 | On-link bits of pipes B (bit 0) and C (bit 1) |
| peer_lanes | input | 2*LANE_W | Lane counts of pipes B (low field) and C (high field) |
| res_valid | output | 1 | One-cycle result pulse |
| res_lanes | output | LANE_W | Lane count from the last test |
| res_bpp | output | BPP_W | Depth used in the last test |
| res_ok | output | 1 | Final test passed |
| res_bw_limited | output | 1 | Depth was lowered at least once |
| res_retry | output | 1 | Passed after lowering; the caller must redo its configuration |

## Verification
The assertions assume that every request input is stable on the edge where the request is taken. They also assume that peer lane counts and depths fit their fields, since only the values captured on that edge count. The checker records the starting depth and mode on that edge so it can relate them to the result, and it assumes nothing changes them between the edge and the pulse. The stimulus changes inputs only on falling edges. It drops `req_valid` right after the request is taken and keeps every other field unchanged until the result pulse has been seen.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL       = 2'd0,
    MODE_TRIPLE     = 2'd1,
    MODE_NARROW     = 2'd2,
    MODE_NARROW_ALT = 2'd3
  } plat_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EVAL = 1'b1
  } state_e;

  localparam int LINK_MAX_LANES = 4;
  localparam int SHARE_LANES    = 2;
  localparam int BPP_FLOOR      = 18;
  localparam int BPP_STEP       = 6;
  localparam int NUM_PEERS      = 2;
endpackage

// File: rtl/lbc_lane_calc.sv
module lbc_lane_calc #(
  parameter int PCLK_W = 20,
  parameter int BW_W   = 20,
  parameter int BPP_W  = 8,
  parameter int LANE_W = 4
) (
  input  logic [PCLK_W-1:0] pclk,
  input  logic [BW_W-1:0]   lane_bw,
  input  logic [BPP_W-1:0]  bpp,
  output logic [LANE_W-1:0] lanes
);
  localparam int NUM_W = PCLK_W + BPP_W;
  localparam int DEN_W = BW_W + 3;
  localparam int SUM_W = ((NUM_W > DEN_W) ? NUM_W : DEN_W) + 1;
  localparam logic [LANE_W-1:0] LMAX = {LANE_W{1'b1}};

  logic [SUM_W-1:0] den;
  logic [SUM_W-1:0] num;
  logic [SUM_W-1:0] quot;

  always_comb begin
    den  = SUM_W'({lane_bw, 3'b000});
    num  = SUM_W'(pclk) * SUM_W'(bpp) + den - SUM_W'(1);
    quot = '0;
    if (lane_bw == '0) begin
      lanes = LMAX;
    end else begin
      quot  = num / den;
      lanes = (quot > SUM_W'(LMAX)) ? LMAX : quot[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/lbc_peer_need.sv
module lbc_peer_need #(
  parameter int LANE_W = 4
) (
  input  logic              en,
  input  logic              on_link,
  input  logic [LANE_W-1:0] lanes,
  output logic [LANE_W-1:0] need
);
  assign need = (en && on_link) ? lanes : '0;
endmodule

// File: rtl/lbc_rules.sv
module lbc_rules
  import lbc_pkg::*;
#(
  parameter int LANE_W = 4
) (
  input  plat_mode_e        mode,
  input  logic [1:0]        pipe,
  input  logic [LANE_W-1:0] lanes,
  input  logic [LANE_W-1:0] need_b,
  input  logic [LANE_W-1:0] need_c,
  output logic              legal
);
  localparam logic [LANE_W-1:0] MAXL = LANE_W'(LINK_MAX_LANES);
  localparam logic [LANE_W-1:0] SHRL = LANE_W'(SHARE_LANES);

  always_comb begin
    legal = 1'b0;
    if (lanes <= MAXL) begin
      case (mode)
        MODE_DUAL: legal = 1'b1;
        MODE_TRIPLE: begin
          case (pipe)
            2'd0:    legal = 1'b1;
            2'd1:    legal = (lanes <= SHRL) || (need_c == '0);
            2'd2:    legal = (lanes <= SHRL) && (need_b <= SHRL);
            default: legal = 1'b0;
          endcase
        end
        default: legal = (lanes <= SHRL);
      endcase
    end
  end
endmodule

// File: rtl/lane_budget_check.sv
module lane_budget_check
  import lbc_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int BW_W   = 20,
  parameter int BPP_W  = 8,
  parameter int LANE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_pipe,
  input  logic [PCLK_W-1:0]             req_pclk,
  input  logic [BW_W-1:0]               req_lane_bw,
  input  logic [BPP_W-1:0]              req_bpp,
  input  logic [1:0]                    req_mode,
  input  logic [NUM_PEERS-1:0]          peer_en,
  input  logic [NUM_PEERS-1:0]          peer_on_link,
  input  logic [NUM_PEERS*LANE_W-1:0]   peer_lanes,
  output logic                          res_valid,
  output logic [LANE_W-1:0]             res_lanes,
  output logic [BPP_W-1:0]              res_bpp,
  output logic                          res_ok,
  output logic                          res_bw_limited,
  output logic                          res_retry
);
  localparam logic [BPP_W-1:0] FLOOR = BPP_W'(BPP_FLOOR);
  localparam logic [BPP_W-1:0] STEP  = BPP_W'(BPP_STEP);

  state_e                      state;
  plat_mode_e                  cap_mode;
  logic [1:0]                  cap_pipe;
  logic [PCLK_W-1:0]           cap_pclk;
  logic [BW_W-1:0]             cap_bw;
  logic [BPP_W-1:0]            cur_bpp;
  logic [NUM_PEERS-1:0]        cap_en;
  logic [NUM_PEERS-1:0]        cap_link;
  logic [NUM_PEERS*LANE_W-1:0] cap_lanes;
  logic                        lowered;

  logic [LANE_W-1:0] calc_lanes;
  logic [LANE_W-1:0] need [NUM_PEERS];
  logic              legal;
  logic              finish;

  assign req_ready = (state == ST_IDLE);

  lbc_lane_calc #(
    .PCLK_W(PCLK_W), .BW_W(BW_W), .BPP_W(BPP_W), .LANE_W(LANE_W)
  ) u_calc (
    .pclk(cap_pclk), .lane_bw(cap_bw), .bpp(cur_bpp), .lanes(calc_lanes)
  );

  for (genvar g = 0; g < NUM_PEERS; g++) begin : g_peer
    lbc_peer_need #(.LANE_W(LANE_W)) u_need (
      .en(cap_en[g]),
      .on_link(cap_link[g]),
      .lanes(cap_lanes[g*LANE_W +: LANE_W]),
      .need(need[g])
    );
  end

  lbc_rules #(.LANE_W(LANE_W)) u_rules (
    .mode(cap_mode), .pipe(cap_pipe), .lanes(calc_lanes),
    .need_b(need[0]), .need_c(need[1]), .legal(legal)
  );

  assign finish = legal || (cur_bpp <= FLOOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      cap_mode       <= MODE_DUAL;
      cap_pipe       <= '0;
      cap_pclk       <= '0;
      cap_bw         <= '0;
      cur_bpp        <= '0;
      cap_en         <= '0;
      cap_link       <= '0;
      cap_lanes      <= '0;
      lowered        <= 1'b0;
      res_valid      <= 1'b0;
      res_lanes      <= '0;
      res_bpp        <= '0;
      res_ok         <= 1'b0;
      res_bw_limited <= 1'b0;
      res_retry      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state     <= ST_EVAL;
            cap_mode  <= plat_mode_e'(req_mode);
            cap_pipe  <= req_pipe;
            cap_pclk  <= req_pclk;
            cap_bw    <= req_lane_bw;
            cur_bpp   <= req_bpp;
            cap_en    <= peer_en;
            cap_link  <= peer_on_link;
            cap_lanes <= peer_lanes;
            lowered   <= 1'b0;
          end
        end
        default: begin
          if (finish) begin
            state          <= ST_IDLE;
            res_valid      <= 1'b1;
            res_lanes      <= calc_lanes;
            res_bpp        <= cur_bpp;
            res_ok         <= legal;
            res_bw_limited <= lowered;
            res_retry      <= legal && lowered;
          end else begin
            cur_bpp <= cur_bpp - STEP;
            lowered <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
  parameter int BPP_W  = 8,
  parameter int LANE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BPP_W-1:0]  req_bpp,
  input logic [1:0]        req_mode,
  input logic              res_valid,
  input logic [LANE_W-1:0] res_lanes,
  input logic [BPP_W-1:0]  res_bpp,
  input logic              res_ok,
  input logic              res_bw_limited,
  input logic              res_retry
);
  logic [BPP_W-1:0] seen_bpp;
  logic [1:0]       seen_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_bpp  <= '0;
      seen_mode <= '0;
    end else if (req_valid && req_ready) begin
      seen_bpp  <= req_bpp;
      seen_mode <= req_mode;
    end
  end

  a_r1_wide_never_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_lanes > LANE_W'(4)) |-> !res_ok);

  a_r2_restricted_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ok && seen_mode[1]) |-> (res_lanes <= LANE_W'(2)));

  a_r8_depth_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_bw_limited) |-> (res_bpp == seen_bpp));

  a_r8_depth_lowered: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_bw_limited) |-> (res_bpp < seen_bpp));

  a_r9_retry_means_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_retry) |-> (res_ok && res_bw_limited));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind lane_budget_check lbc_checker #(.BPP_W(BPP_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bpp(req_bpp), .req_mode(req_mode), .res_valid(res_valid),
  .res_lanes(res_lanes), .res_bpp(res_bpp), .res_ok(res_ok),
  .res_bw_limited(res_bw_limited), .res_retry(res_retry)
);

// File: tb/sim_lane_budget_check.sv
module sim_lane_budget_check;
  localparam int PCLK_W = 20;
  localparam int BW_W   = 20;
  localparam int BPP_W  = 8;
  localparam int LANE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_pipe = '0;
  logic [PCLK_W-1:0] req_pclk = '0;
  logic [BW_W-1:0] req_lane_bw = '0;
  logic [BPP_W-1:0] req_bpp = '0;
  logic [1:0] req_mode = '0;
  logic [1:0] peer_en = '0;
  logic [1:0] peer_on_link = '0;
  logic [2*LANE_W-1:0] peer_lanes = '0;
  logic res_valid;
  logic [LANE_W-1:0] res_lanes;
  logic [BPP_W-1:0] res_bpp;
  logic res_ok, res_bw_limited, res_retry;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lane_budget_check #(.PCLK_W(PCLK_W), .BW_W(BW_W), .BPP_W(BPP_W), .LANE_W(LANE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pipe(req_pipe), .req_pclk(req_pclk), .req_lane_bw(req_lane_bw),
    .req_bpp(req_bpp), .req_mode(req_mode), .peer_en(peer_en),
    .peer_on_link(peer_on_link), .peer_lanes(peer_lanes), .res_valid(res_valid),
    .res_lanes(res_lanes), .res_bpp(res_bpp), .res_ok(res_ok),
    .res_bw_limited(res_bw_limited), .res_retry(res_retry)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int ref_lanes(input longint pclk, input longint bw, input longint bpp);
    longint q;
    if (bw == 0) return 15;
    q = (pclk * bpp + bw * 8 - 1) / (bw * 8);
    return (q > 15) ? 15 : int'(q);
  endfunction

  function automatic bit ref_legal(input int mode, input int pipe, input int ln,
                                   input int nb, input int nc);
    if (ln > 4) return 1'b0;
    if (mode == 0) return 1'b1;
    if (mode >= 2) return ln <= 2;
    if (pipe == 0) return 1'b1;
    if (pipe == 1) return (ln <= 2) || (nc == 0);
    if (pipe == 2) return (ln <= 2) && (nb <= 2);
    return 1'b0;
  endfunction

  task automatic run_case(input string tag, input int pipe, input int pclk, input int bw,
                          input int bpp, input int mode, input bit [1:0] en,
                          input bit [1:0] link, input int lb, input int lc);
    int nb, nc, cur, ln, evals;
    bit ok, lim;
    nb = (en[0] && link[0]) ? lb : 0;
    nc = (en[1] && link[1]) ? lc : 0;
    cur = bpp; lim = 1'b0; evals = 0;
    while (1) begin
      evals++;
      ln = ref_lanes(pclk, bw, cur);
      ok = ref_legal(mode, pipe, ln, nb, nc);
      if (ok || cur <= 18) break;
      cur -= 6;
      lim = 1'b1;
    end
    @(negedge clk);
    chk(tag, "ready idle", req_ready, 1);
    req_pipe = 2'(pipe); req_pclk = PCLK_W'(pclk); req_lane_bw = BW_W'(bw);
    req_bpp = BPP_W'(bpp); req_mode = 2'(mode); peer_en = en; peer_on_link = link;
    peer_lanes = {LANE_W'(lc), LANE_W'(lb)};
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "ready busy", req_ready, 0);
    chk(tag, "no early result", res_valid, 0);
    for (int k = 1; k <= evals; k++) begin
      @(negedge clk);
      chk(tag, "res_valid timing", res_valid, (k == evals) ? 1 : 0);
      chk(tag, "ready timing", req_ready, (k == evals) ? 1 : 0);
      if (k == evals) begin
        chk(tag, "lanes", res_lanes, ln);
        chk(tag, "bpp", res_bpp, cur);
        chk(tag, "ok", res_ok, ok);
        chk(tag, "bw_limited", res_bw_limited, lim);
        chk(tag, "retry", res_retry, ok && lim);
      end
    end
    @(negedge clk);
    chk(tag, "pulse ends", res_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "ready after reset", req_ready, 1);
    chk("R11", "res_valid after reset", res_valid, 0);
    chk("R11", "ok after reset", res_ok, 0);
    chk("R11", "retry after reset", res_retry, 0);
    chk("R11", "limited after reset", res_bw_limited, 0);
    rst_n = 1'b1;

    run_case("R3 two-pipe fit",        1, 148500, 270000, 24, 0, 2'b11, 2'b11, 4, 4);
    run_case("R3 R9 two-pipe reduce",  2, 300000, 270000, 30, 0, 2'b11, 2'b11, 4, 4);
    run_case("R7 exact ceiling",       0, 270000, 270000, 32, 0, 2'b00, 2'b00, 0, 0);
    run_case("R1 R8 never fits",       0, 600000, 270000, 36, 0, 2'b00, 2'b00, 0, 0);
    run_case("R9 floor no drop",       0, 600000, 270000, 18, 0, 2'b00, 2'b00, 0, 0);
    run_case("R4 pipe A four",         0, 300000, 270000, 24, 1, 2'b11, 2'b11, 4, 2);
    run_case("R4 R8 B shares C",       1, 200000, 270000, 24, 1, 2'b10, 2'b10, 0, 1);
    run_case("R4 B blocked to floor",  1, 300000, 270000, 24, 1, 2'b10, 2'b10, 0, 1);
    run_case("R6 C off link",          1, 300000, 270000, 24, 1, 2'b10, 2'b00, 0, 2);
    run_case("R6 C disabled",          1, 300000, 270000, 24, 1, 2'b00, 2'b10, 0, 2);
    run_case("R5 C over two",          2, 200000, 270000, 24, 1, 2'b00, 2'b00, 0, 0);
    run_case("R5 C blocked by B",      2, 148500, 270000, 24, 1, 2'b01, 2'b01, 3, 0);
    run_case("R5 R6 B disabled",       2, 148500, 270000, 24, 1, 2'b00, 2'b01, 3, 0);
    run_case("R5 pipe index three",    3, 100000, 270000, 24, 1, 2'b00, 2'b00, 0, 0);
    run_case("R2 restricted reduce",   0, 200000, 270000, 24, 2, 2'b00, 2'b00, 0, 0);
    run_case("R2 alt code reduce",     0, 200000, 270000, 24, 3, 2'b00, 2'b00, 0, 0);
    run_case("R2 no sharing check",    2, 148500, 270000, 24, 2, 2'b01, 2'b01, 4, 0);
    run_case("R7 zero bandwidth",      0, 148500, 0,      24, 0, 2'b00, 2'b00, 0, 0);
    run_case("R7 saturate",            0, 1048575, 1,    255, 0, 2'b00, 2'b00, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule